// File: doc/BRIEF.md
# Three-State Snoopy Coherence Controller

This block keeps one write-back cache coherent with its peers on a single shared bus backed by main memory. It holds a small direct-mapped array of lines. Each line is Invalid, Clean or Dirty. Main memory keeps no state of its own. On the processor side the block accepts read and write requests. Hits are served locally when no other copy needs to be told. Every other case is a bus transaction. The block requests the bus, waits for the grant and then runs its whole command sequence before it lets the bus go. The bus is never split between an address phase and a data phase.

On the snoop side the block watches commands that other caches put on the bus. A snooped read miss to a line held Dirty makes this cache supply the data. The same signal tells memory not to answer and to take the data as a write instead of a read. The line then drops to Clean. A snooped write miss invalidates a local copy, and a Dirty copy supplies its data as it goes. While the block itself holds the grant, it pays no attention to the snoop port, since the command there is its own.

The processor request and response are valid/ready streams. A request is taken on a cycle where both `cpu_req_valid` and `cpu_req_ready` are high. `cpu_req_ready` is high only while the controller is idle and no foreign snoop is being presented. A response stays valid, with stable data, until `cpu_rsp_ready` is seen high.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, `bus_req`, `cpu_rsp_valid` and `snp_supply` are low, and the first read of any address is a bus read miss.
- R2: A read whose line holds the address in Clean (state code 1) or Dirty (code 2) returns the stored word one cycle after acceptance and never raises `bus_req`.
- R3: A read miss raises `bus_req`. Once granted, the block issues command code 1 (read miss) with the request address. It then waits for `fill_valid`, installs the line as Clean and returns the fill word. A Clean victim is dropped without bus traffic.
- R4: A write miss issues command code 2 (write miss) with the request address, waits for `fill_valid` and installs the line as Dirty holding the write data.
- R5: A write hit on a Clean line issues command code 2 for that address, does not wait for a fill, and leaves the line Dirty with the write data.
- R6: A write hit on a Dirty line updates the word with no bus request.
- R7: A miss that evicts a Dirty line first issues command code 3 (writeback) with the victim address (victim tag above the index bits) and its data. The miss command follows in the very next cycle. `bus_req` stays high until the fill is taken, and `bus_cmd_valid` is only ever high while `bus_grant` is high.
- R8: A snooped read miss (code 1) that matches a Dirty line raises `snp_supply` in the same cycle with the line's word on `snp_data`. The line becomes Clean, so a later local write to it issues a write miss.
- R9: A snooped write miss (code 2) that matches a valid line makes it Invalid. If the line was Dirty, it supplies its word the same way as R8.
- R10: Snoops are ignored while `bus_grant` is high. Snooped writebacks (code 3) and snoops whose tag differs from the line's tag are ignored as well.
- R11: If a snoop invalidates the line of a pending Clean write hit while the block waits for the grant, the request is served as a write miss (code 2 followed by a fill). The final word is the write data.
- R12: `cpu_req_ready` is low while a snoop is presented without the grant. A response held by a low `cpu_rsp_ready` keeps `cpu_rsp_valid` high and its data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request can be taken this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Response accepted |
| cpu_rsp_rdata | output | DATA_W | Read data (zero for writes) |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership granted |
| bus_cmd_valid | output | 1 | Own command on the bus this cycle |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 writeback |
| bus_addr | output | ADDR_W | Address of the own command |
| bus_wdata | output | DATA_W | Writeback data (zero otherwise) |
| fill_valid | input | 1 | Fill word for the pending miss present |
| fill_data | input | DATA_W | Fill word from memory or a peer cache |
| snp_valid | input | 1 | Foreign command on the bus |
| snp_cmd | input | 2 | Foreign command code, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Foreign command address |
| snp_supply | output | 1 | This cache supplies data and inhibits memory |
| snp_data | output | DATA_W | Word supplied on a snoop |

## Verification
The bench goes after the cases where the sequence of bus commands is easy to get wrong. A miss that evicts a Dirty line must put the writeback before the miss, or memory is left stale. A write hit on a Clean line that skips the write miss leaves peer copies alive. A design that waits for a fill on an upgrade hangs. Snoops are presented during the grant wait, so a controller that decides upgrade-versus-miss from the state seen at request time would issue an upgrade on an invalidated line and never fetch it. Snoops are also presented while the grant is held, to catch a block that obeys its own command. A missed downgrade after supplying data shows up later as a write hit with no bus command.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_CLN = 2'd1,
    LS_DRT = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor-side lookup and write
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic              cw_en,
  input  line_st_e          cw_st,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic [DATA_W-1:0] cw_data,
  // snoop-side lookup and state write
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              sw_en,
  input  line_st_e          sw_st
);

  localparam int LINES = 1 << IDX_W;

  line_st_e          st_v  [LINES];
  logic [TAG_W-1:0]  tag_v [LINES];
  logic [DATA_W-1:0] dat_v [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= LS_INV;
        tag_r <= '0;
        dat_r <= '0;
      end else if (cw_en && a_idx == IDX_W'(i)) begin
        st_r  <= cw_st;
        tag_r <= cw_tag;
        dat_r <= cw_data;
      end else if (sw_en && b_idx == IDX_W'(i)) begin
        st_r  <= sw_st;
      end
    end

    assign st_v[i]  = st_r;
    assign tag_v[i] = tag_r;
    assign dat_v[i] = dat_r;
  end

  assign a_st   = st_v[a_idx];
  assign a_tag  = tag_v[a_idx];
  assign a_data = dat_v[a_idx];
  assign b_st   = st_v[b_idx];
  assign b_tag  = tag_v[b_idx];
  assign b_data = dat_v[b_idx];

  // R12
  no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw_en && sw_en))
    else $error("processor and snoop wrote the state array in one cycle");

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              bus_grant,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_e          lk_st,
  input  logic [ADDR_W-IDX_W-1:0] lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  output logic              sw_en,
  output line_st_e          sw_st,
  output logic              busy,
  output logic              supply,
  output logic [DATA_W-1:0] supply_data
);

  logic active, match, dirty;

  assign lk_idx = snp_addr[IDX_W-1:0];
  assign active = snp_valid && !bus_grant;
  assign busy   = active;
  assign match  = active && (lk_st != LS_INV) && (lk_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign dirty  = match && (lk_st == LS_DRT);

  always_comb begin
    sw_en  = 1'b0;
    sw_st  = lk_st;
    supply = 1'b0;
    unique case (snp_cmd)
      BC_RDMISS: begin
        if (dirty) begin
          sw_en  = 1'b1;
          sw_st  = LS_CLN;
          supply = 1'b1;
        end
      end
      BC_WRMISS: begin
        if (match) begin
          sw_en  = 1'b1;
          sw_st  = LS_INV;
          supply = dirty;
        end
      end
      default: ;
    endcase
  end

  assign supply_data = supply ? lk_data : '0;

  // R10
  supply_not_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> !bus_grant)
    else $error("snoop answered while owning the bus");

endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              cmd_valid,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snoop_busy,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_e          lk_st,
  input  logic [ADDR_W-IDX_W-1:0] lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  output logic              wr_en,
  output line_st_e          wr_st,
  output logic [ADDR_W-IDX_W-1:0] wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_WB, S_MISS, S_FILL, S_UPG, S_RESP
  } fsm_e;

  fsm_e              st_q, st_d;
  logic              r_write;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, r_rdata, rdata_d;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit, accept;

  assign lk_idx    = (st_q == S_IDLE) ? req_addr[IDX_W-1:0] : r_addr[IDX_W-1:0];
  assign cur_tag   = (st_q == S_IDLE) ? req_addr[ADDR_W-1:IDX_W] : r_addr[ADDR_W-1:IDX_W];
  assign hit       = (lk_st != LS_INV) && (lk_tag == cur_tag);
  assign req_ready = (st_q == S_IDLE) && !snoop_busy;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (st_q == S_RESP);
  assign rsp_rdata = r_rdata;
  assign bus_req   = (st_q == S_WAIT) || (st_q == S_WB) || (st_q == S_MISS) ||
                     (st_q == S_FILL) || (st_q == S_UPG);

  always_comb begin
    st_d      = st_q;
    rdata_d   = r_rdata;
    wr_en     = 1'b0;
    wr_st     = lk_st;
    wr_tag    = lk_tag;
    wr_data   = lk_data;
    cmd_valid = 1'b0;
    cmd       = BC_NONE;
    cmd_addr  = r_addr;
    cmd_wdata = '0;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          rdata_d = '0;
          if (hit && !req_write) begin
            rdata_d = lk_data;
            st_d    = S_RESP;
          end else if (hit && lk_st == LS_DRT) begin
            wr_en   = 1'b1;
            wr_data = req_wdata;
            st_d    = S_RESP;
          end else begin
            st_d = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (bus_grant) begin
          if (hit && r_write)       st_d = S_UPG;
          else if (lk_st == LS_DRT) st_d = S_WB;
          else                      st_d = S_MISS;
        end
      end
      S_WB: begin
        cmd_valid = 1'b1;
        cmd       = BC_WBACK;
        cmd_addr  = {lk_tag, r_addr[IDX_W-1:0]};
        cmd_wdata = lk_data;
        wr_en     = 1'b1;
        wr_st     = LS_INV;
        st_d      = S_MISS;
      end
      S_MISS: begin
        cmd_valid = 1'b1;
        cmd       = r_write ? BC_WRMISS : BC_RDMISS;
        st_d      = S_FILL;
      end
      S_FILL: begin
        if (fill_valid) begin
          wr_en   = 1'b1;
          wr_tag  = r_addr[ADDR_W-1:IDX_W];
          wr_st   = r_write ? LS_DRT : LS_CLN;
          wr_data = r_write ? r_wdata : fill_data;
          if (!r_write) rdata_d = fill_data;
          st_d    = S_RESP;
        end
      end
      S_UPG: begin
        cmd_valid = 1'b1;
        cmd       = BC_WRMISS;
        wr_en     = 1'b1;
        wr_st     = LS_DRT;
        wr_data   = r_wdata;
        st_d      = S_RESP;
      end
      S_RESP: begin
        if (rsp_ready) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_rdata <= '0;
    end else begin
      st_q    <= st_d;
      r_rdata <= rdata_d;
      if (accept) begin
        r_write <= req_write;
        r_addr  <= req_addr;
        r_wdata <= req_wdata;
      end
    end
  end

  // R2
  read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit) |=> (rsp_valid && !bus_req))
    else $error("read hit went to the bus");

  // R7
  cmd_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> bus_grant)
    else $error("command driven without grant");

  // R7
  wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == BC_WBACK) |=> (cmd_valid && (cmd == BC_RDMISS || cmd == BC_WRMISS)))
    else $error("writeback not followed by miss command");

  // R7
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> rsp_valid)
    else $error("bus released before the transaction finished");

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)))
    else $error("response dropped or changed under back-pressure");

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_e          a_st, b_st, cw_st, sw_st;
  logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
  logic [DATA_W-1:0] a_data, b_data, cw_data;
  logic              cw_en, sw_en, snp_busy;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .cw_en(cw_en), .cw_st(cw_st), .cw_tag(cw_tag), .cw_data(cw_data),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .sw_en(sw_en), .sw_st(sw_st)
  );

  coh_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready),
    .req_write(cpu_req_write), .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata),
    .rsp_valid(cpu_rsp_valid), .rsp_ready(cpu_rsp_ready), .rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .cmd_valid(bus_cmd_valid), .cmd(bus_cmd), .cmd_addr(bus_addr), .cmd_wdata(bus_wdata),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .snoop_busy(snp_busy),
    .lk_idx(a_idx), .lk_st(a_st), .lk_tag(a_tag), .lk_data(a_data),
    .wr_en(cw_en), .wr_st(cw_st), .wr_tag(cw_tag), .wr_data(cw_data)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .bus_grant(bus_grant),
    .lk_idx(b_idx), .lk_st(b_st), .lk_tag(b_tag), .lk_data(b_data),
    .sw_en(sw_en), .sw_st(sw_st), .busy(snp_busy),
    .supply(snp_supply), .supply_data(snp_data)
  );

endmodule

// File: tb/coh_snoop_ctrl_bench.sv
module coh_snoop_ctrl_bench;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int DW = 16;
  localparam int LN = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic cpu_rsp_valid, cpu_rsp_ready;
  logic [DW-1:0] cpu_rsp_rdata;
  logic bus_req, bus_grant, bus_cmd_valid;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic fill_valid;
  logic [DW-1:0] fill_data;
  logic snp_valid;
  logic [1:0] snp_cmd;
  logic [AW-1:0] snp_addr;
  logic snp_supply;
  logic [DW-1:0] snp_data;

  coh_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_coh_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_data(snp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]     ref_st  [LN];
  logic [AW-IW-1:0] ref_tag [LN];
  logic [DW-1:0]  ref_dat [LN];
  logic [DW-1:0]  mem     [64];

  logic [1:0]    lg_cmd [8];
  logic [AW-1:0] lg_addr[8];
  logic [DW-1:0] lg_data[8];
  int nlg;
  logic [1:0]    ex_cmd [8];
  logic [AW-1:0] ex_addr[8];
  logic [DW-1:0] ex_data[8];
  int nex;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_exp(logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] d);
    ex_cmd[nex] = c; ex_addr[nex] = a; ex_data[nex] = d; nex++;
  endtask

  task automatic ref_snoop(logic [1:0] c, logic [AW-1:0] a, output bit sup, output logic [DW-1:0] d);
    int i;
    bit m;
    i = int'(a[IW-1:0]);
    m = (ref_st[i] != 2'd0) && (ref_tag[i] == a[AW-1:IW]);
    sup = 1'b0; d = '0;
    if (m && c == 2'd1 && ref_st[i] == 2'd2) begin
      sup = 1'b1; d = ref_dat[i]; mem[a] = ref_dat[i]; ref_st[i] = 2'd1;
    end else if (m && c == 2'd2) begin
      if (ref_st[i] == 2'd2) begin
        sup = 1'b1; d = ref_dat[i]; mem[a] = ref_dat[i];
      end
      ref_st[i] = 2'd0;
    end
  endtask

  task automatic do_snoop(logic [1:0] c, logic [AW-1:0] a, string req);
    bit sup;
    logic [DW-1:0] d;
    ref_snoop(c, a, sup, d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    chk(snp_supply == sup, req, 32'(snp_supply), 32'(sup));
    if (sup) chk(snp_data == d, req, 32'(snp_data), 32'(d));
    chk(cpu_req_ready == 1'b0, "R12 ready during snoop", 32'(cpu_req_ready), 32'd0);
    @(negedge clk);
    snp_valid = 1'b0;
    if (c == 2'd2) mem[a] = DW'($urandom);
  endtask

  task automatic do_op(bit w, logic [AW-1:0] a, logic [DW-1:0] wd, bit snp_wait,
                       logic [1:0] sc, logic [AW-1:0] sa, int gdly, int rdly);
    int i;
    logic [AW-IW-1:0] t;
    bit hit, needbus, sup, saw_req, got, fill_nxt, snp_done;
    logic [DW-1:0] sd, exp_rd, rdata, hold;
    int waited, rcnt;
    string cat;
    i = int'(a[IW-1:0]);
    t = a[AW-1:IW];
    nex = 0; exp_rd = '0; nlg = 0;
    hit = (ref_st[i] != 2'd0) && (ref_tag[i] == t);
    needbus = !(hit && (!w || ref_st[i] == 2'd2));
    if (!needbus) cat = w ? "R6" : "R2";
    else if (snp_wait) cat = "R11";
    else if (w && hit) cat = "R5";
    else if (ref_st[i] == 2'd2) cat = "R7";
    else cat = w ? "R4" : "R3";
    if (!needbus) begin
      if (!w) exp_rd = ref_dat[i]; else ref_dat[i] = wd;
    end else begin
      if (snp_wait) ref_snoop(sc, sa, sup, sd);
      hit = (ref_st[i] != 2'd0) && (ref_tag[i] == t);
      if (w && hit) begin
        add_exp(2'd2, a, '0);
        ref_st[i] = 2'd2; ref_dat[i] = wd;
      end else begin
        if (ref_st[i] == 2'd2) begin
          add_exp(2'd3, {ref_tag[i], a[IW-1:0]}, ref_dat[i]);
          mem[{ref_tag[i], a[IW-1:0]}] = ref_dat[i];
        end
        add_exp(w ? 2'd2 : 2'd1, a, '0);
        ref_tag[i] = t;
        if (w) begin ref_st[i] = 2'd2; ref_dat[i] = wd; end
        else begin ref_st[i] = 2'd1; ref_dat[i] = mem[a]; exp_rd = mem[a]; end
      end
    end
    // drive the request
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    waited = 0; rcnt = 0; got = 1'b0; fill_nxt = 1'b0; snp_done = 1'b0;
    saw_req = 1'b0; rdata = '0; hold = '0;
    for (int k = 0; k < 60 && !got; k++) begin
      #1;
      fill_valid = fill_nxt; fill_data = mem[a]; fill_nxt = 1'b0;
      snp_valid = 1'b0;
      if (bus_req) saw_req = 1'b1;
      if (bus_cmd_valid && nlg < 8) begin
        lg_cmd[nlg] = bus_cmd; lg_addr[nlg] = bus_addr; lg_data[nlg] = bus_wdata; nlg++;
        if (bus_cmd == 2'd1 || bus_cmd == 2'd2) fill_nxt = 1'b1;
      end
      if (bus_req && !bus_grant) begin
        if (snp_wait && !snp_done) begin
          snp_valid = 1'b1; snp_cmd = sc; snp_addr = sa; snp_done = 1'b1;
        end else if (waited >= gdly) bus_grant = 1'b1;
        else waited++;
      end else if (!bus_req) bus_grant = 1'b0;
      if (cpu_rsp_valid) begin
        if (rcnt == 0) hold = cpu_rsp_rdata;
        if (rcnt == rdly) begin
          rdata = cpu_rsp_rdata; cpu_rsp_ready = 1'b1; got = 1'b1;
          if (rdly > 0) chk(rdata == hold, "R12 response stable", 32'(rdata), 32'(hold));
        end else rcnt++;
      end
      @(negedge clk);
    end
    cpu_rsp_ready = 1'b0; fill_valid = 1'b0; snp_valid = 1'b0; bus_grant = 1'b0;
    chk(got, {cat, " response arrived"}, 32'(got), 32'd1);
    chk(nlg == nex, {cat, " bus command count"}, 32'(nlg), 32'(nex));
    for (int j = 0; j < nex && j < nlg; j++) begin
      chk(lg_cmd[j] == ex_cmd[j], {cat, " bus command code"}, 32'(lg_cmd[j]), 32'(ex_cmd[j]));
      chk(lg_addr[j] == ex_addr[j], {cat, " bus command address"}, 32'(lg_addr[j]), 32'(ex_addr[j]));
      if (ex_cmd[j] == 2'd3)
        chk(lg_data[j] == ex_data[j], {cat, " writeback data"}, 32'(lg_data[j]), 32'(ex_data[j]));
    end
    if (!w) chk(rdata == exp_rd, {cat, " read data"}, 32'(rdata), 32'(exp_rd));
    if (!needbus) chk(!saw_req, {cat, " no bus request"}, 32'(saw_req), 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd20031112));
    for (int k = 0; k < LN; k++) begin ref_st[k] = 2'd0; ref_tag[k] = '0; ref_dat[k] = '0; end
    for (int k = 0; k < 64; k++) mem[k] = DW'($urandom);
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    cpu_rsp_ready = 1'b0; bus_grant = 1'b0; fill_valid = 1'b0; fill_data = '0;
    snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(cpu_req_ready == 1'b1, "R1 ready", 32'(cpu_req_ready), 32'd1);
    chk(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 32'd0);
    chk(cpu_rsp_valid == 1'b0, "R1 rsp_valid", 32'(cpu_rsp_valid), 32'd0);
    chk(snp_supply == 1'b0, "R1 supply", 32'(snp_supply), 32'd0);

    // R1/R3 first read misses; R2 hit; R5 upgrade; R6 dirty write hit
    do_op(1'b0, 6'h05, '0, 1'b0, 2'd0, '0, 0, 0);
    do_op(1'b0, 6'h05, '0, 1'b0, 2'd0, '0, 0, 0);
    do_op(1'b1, 6'h05, 16'hA5A5, 1'b0, 2'd0, '0, 2, 0);
    do_op(1'b1, 6'h05, 16'h1234, 1'b0, 2'd0, '0, 0, 0);
    do_op(1'b0, 6'h05, '0, 1'b0, 2'd0, '0, 0, 0);
    // R7 dirty victim
    do_op(1'b0, 6'h09, '0, 1'b0, 2'd0, '0, 1, 0);
    // R4 write miss
    do_op(1'b1, 6'h0A, 16'hBEEF, 1'b0, 2'd0, '0, 0, 0);
    // R8 supply and downgrade, then write issues a write miss
    do_snoop(2'd1, 6'h0A, "R8 supply on read miss");
    do_op(1'b1, 6'h0A, 16'hCAFE, 1'b0, 2'd0, '0, 0, 0);
    // R9 dirty invalidate with supply, then read misses
    do_snoop(2'd2, 6'h0A, "R9 dirty invalidate");
    do_op(1'b0, 6'h0A, '0, 1'b0, 2'd0, '0, 0, 0);
    do_op(1'b0, 6'h0B, '0, 1'b0, 2'd0, '0, 0, 0);
    do_snoop(2'd2, 6'h0B, "R9 clean invalidate");
    do_op(1'b0, 6'h0B, '0, 1'b0, 2'd0, '0, 0, 0);
    // R10 snoop while owning is ignored
    do_op(1'b1, 6'h09, 16'h7777, 1'b0, 2'd0, '0, 0, 0);
    @(negedge clk);
    bus_grant = 1'b1; snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 6'h09;
    #1;
    chk(snp_supply == 1'b0, "R10 no supply while owning", 32'(snp_supply), 32'd0);
    @(negedge clk);
    snp_valid = 1'b0; bus_grant = 1'b0;
    do_op(1'b0, 6'h09, '0, 1'b0, 2'd0, '0, 0, 0);
    do_snoop(2'd3, 6'h09, "R10 writeback snoop ignored");
    do_snoop(2'd2, 6'h0D, "R10 tag mismatch ignored");
    do_op(1'b0, 6'h09, '0, 1'b0, 2'd0, '0, 0, 0);
    // R11 pending upgrade turned into a write miss
    do_op(1'b0, 6'h0C, '0, 1'b0, 2'd0, '0, 0, 0);
    do_op(1'b1, 6'h0C, 16'h5A5A, 1'b1, 2'd2, 6'h0C, 1, 0);
    do_op(1'b0, 6'h0C, '0, 1'b0, 2'd0, '0, 0, 0);
    // R12 response back-pressure
    do_op(1'b0, 6'h0C, '0, 1'b0, 2'd0, '0, 0, 3);
    do_op(1'b0, 6'h20, '0, 1'b0, 2'd0, '0, 0, 2);

    // constrained random phase
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom_range(0, 63));
      if ($urandom_range(0, 3) == 0) begin
        do_snoop(2'($urandom_range(1, 3)), ra, "R9 random snoop");
      end else begin
        do_op(1'($urandom_range(0, 1)), ra, DW'($urandom),
              ($urandom_range(0, 7) == 0), 2'($urandom_range(1, 2)),
              {AW'($urandom_range(0, 63))}, $urandom_range(0, 3), $urandom_range(0, 2));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule